// File: doc/BRIEF.md
# Bank-Crossing Wait-State Inserter

This block sits on a processor's memory request path, between the port that issues accesses and the memory banks behind it. It remembers the bank and the address space of the last access that completed. Every new request is compared against that record. When the new access lands in another bank, or moves between program space and data space, the block holds off the requester for one cycle by dropping its ready line. It then accepts the request and forwards it to memory one cycle later. The added cycle gives the bank selection logic time to settle.

A small control register sets the policy. A 4-bit mask chooses which of the four top address bits take part in bank detection. One enable bit decides whether a program read followed by a data read is penalised. Four more bits are plain storage with no effect on timing. The requester presents a request with valid, address and a 2-bit space code, and it must hold that request unchanged until ready is seen high.

Top module: `bank_cross_waiter`

## Requirements
- R1: After a synchronous reset the control register reads 0x001F, ready is high and the forwarded valid is low. In that value the mask (bits 3:0) is 1111, the program-read-to-data-read enable (bit 4) is 1, and the storage bits 8:5 are 0.
- R2: The first request after reset is accepted in the cycle it is presented, because no earlier access is on record.
- R3: The bank of an access is address bits [15:12] ANDed with the mask. When the bank differs from the bank of the last completed access, ready is low for exactly one cycle and the request is then accepted.
- R4: A mask bit at 0 leaves the matching address bit out of bank detection. With a mask of 0000, no bank stall happens.
- R5: The space code uses bit 1 for space (0 program, 1 data) and bit 0 for direction (0 read, 1 write). A change of space bit between the last completed access and the new one costs one wait cycle, except in the case covered by R6.
- R6: A program read (00) followed by a data read (10) stalls only while control bit 4 is 1.
- R7: An access accepted at a clock edge appears on mem_valid, mem_addr and mem_space for the following cycle. mem_valid is low after every edge at which nothing was accepted, including wait cycles.
- R8: The record of the last access changes only when an access completes. A request that is stalled and then withdrawn leaves the record unchanged.
- R9: Control bits 8:0 are writable, and bits 15:9 read as 0. Bits 8:5 have no effect on stalling.
- R10: An access in the same bank and the same space as the last completed access is accepted with no wait, and ready is high whenever no request is presented.
- R11: A held request is never stalled twice in a row: after one wait cycle it is accepted whatever it crosses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 16 | Request address |
| req_space | input | 2 | Space code: bit 1 data/program, bit 0 write/read |
| req_ready | output | 1 | Request accepted at this edge when high with req_valid |
| mem_valid | output | 1 | Forwarded request valid (registered) |
| mem_addr | output | 16 | Forwarded address |
| mem_space | output | 2 | Forwarded space code |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register contents |

## Verification
The checker watches several properties on every cycle: one-cycle forwarding of each accepted request, mem_valid low after non-accepting edges, no second wait in a row, an unstalled first access, ready when idle, and the register value after reset. Whether a given stall should happen depends on the mask, the enable bit and the stored history. Only the bench's reference model can judge that. Its scenarios cover masked-off bit crossings, the enabled and disabled program-read-to-data-read case, and a withdrawn request that must leave the history untouched.

// File: rtl/bxw_pkg.sv
package bxw_pkg;
  localparam int ADDR_W  = 16;
  localparam int MASK_W  = 4;
  localparam int CFG_W   = 16;
  localparam int SPACE_W = 2;

  // control register field positions
  localparam int MASK_LSB   = 0;
  localparam int PD_BIT     = MASK_LSB + MASK_W;
  localparam int STORE_LSB  = PD_BIT + 1;
  localparam int STORE_W    = 4;
  localparam int USED_BITS  = STORE_LSB + STORE_W;

  localparam logic [CFG_W-1:0] CFG_RESET = CFG_W'((1 << (MASK_W + 1)) - 1);

  typedef enum logic [SPACE_W-1:0] {
    SP_PROG_RD = 2'b00,
    SP_PROG_WR = 2'b01,
    SP_DATA_RD = 2'b10,
    SP_DATA_WR = 2'b11
  } space_e;

  typedef struct packed {
    logic [STORE_W-1:0] store;
    logic               pd_en;
    logic [MASK_W-1:0]  mask;
  } cfg_t;

  function automatic logic is_data(input logic [SPACE_W-1:0] sp);
    return sp[1];
  endfunction
endpackage

// File: rtl/bxw_cfg_reg.sv
module bxw_cfg_reg
  import bxw_pkg::*;
#(
  parameter int DW = CFG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output cfg_t          cfg,
  output logic [DW-1:0] rd_data
);
  localparam int FW = $bits(cfg_t);

  cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= cfg_t'(CFG_RESET[FW-1:0]);
    end else if (wr_en) begin
      cfg_q <= cfg_t'(wr_data[FW-1:0]);
    end
  end

  assign cfg = cfg_q;

  generate
    if (DW > FW) begin : g_pad
      assign rd_data = {{(DW-FW){1'b0}}, cfg_q};
    end else begin : g_nopad
      assign rd_data = cfg_q;
    end
  endgenerate
endmodule

// File: rtl/bxw_history.sv
module bxw_history
  import bxw_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = MASK_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic [AW-1:0]      addr,
  input  logic [SPACE_W-1:0] space,
  output logic               prev_valid,
  output logic [BW-1:0]      prev_bank,
  output logic [SPACE_W-1:0] prev_space
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid <= 1'b0;
      prev_bank  <= '0;
      prev_space <= SP_PROG_RD;
    end else if (accept) begin
      prev_valid <= 1'b1;
      prev_bank  <= addr[AW-1 -: BW];
      prev_space <= space;
    end
  end
endmodule

// File: rtl/bxw_cross_detect.sv
module bxw_cross_detect
  import bxw_pkg::*;
#(
  parameter int BW = MASK_W
) (
  input  logic [BW-1:0]      cur_bank,
  input  logic [BW-1:0]      prev_bank,
  input  logic [BW-1:0]      mask,
  input  logic [SPACE_W-1:0] cur_space,
  input  logic [SPACE_W-1:0] prev_space,
  input  logic               pd_en,
  output logic               bank_cross,
  output logic               space_cross
);
  logic [BW-1:0] diff;

  generate
    for (genvar i = 0; i < BW; i++) begin : g_bit
      assign diff[i] = mask[i] & (cur_bank[i] ^ prev_bank[i]);
    end
  endgenerate

  logic class_change;
  logic pr_to_dr;

  always_comb begin
    bank_cross   = |diff;
    class_change = is_data(cur_space) != is_data(prev_space);
    pr_to_dr     = (prev_space == SP_PROG_RD) && (cur_space == SP_DATA_RD);
    space_cross  = class_change && (!pr_to_dr || pd_en);
  end
endmodule

// File: rtl/bank_cross_waiter.sv
module bank_cross_waiter
  import bxw_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = MASK_W,
  parameter int DW = CFG_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [AW-1:0]      req_addr,
  input  logic [SPACE_W-1:0] req_space,
  output logic               req_ready,
  output logic               mem_valid,
  output logic [AW-1:0]      mem_addr,
  output logic [SPACE_W-1:0] mem_space,
  input  logic               cfg_we,
  input  logic [DW-1:0]      cfg_wdata,
  output logic [DW-1:0]      cfg_rdata
);
  cfg_t               cfg;
  logic               prev_valid;
  logic [BW-1:0]      prev_bank;
  logic [SPACE_W-1:0] prev_space;
  logic               bank_cross;
  logic               space_cross;
  logic               waited_q;
  logic               penalty;
  logic               accept;

  bxw_cfg_reg #(.DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .cfg(cfg), .rd_data(cfg_rdata)
  );

  bxw_history #(.AW(AW), .BW(BW)) u_hist (
    .clk(clk), .rst(rst), .accept(accept), .addr(req_addr), .space(req_space),
    .prev_valid(prev_valid), .prev_bank(prev_bank), .prev_space(prev_space)
  );

  bxw_cross_detect #(.BW(BW)) u_det (
    .cur_bank(req_addr[AW-1 -: BW]), .prev_bank(prev_bank), .mask(cfg.mask),
    .cur_space(req_space), .prev_space(prev_space), .pd_en(cfg.pd_en),
    .bank_cross(bank_cross), .space_cross(space_cross)
  );

  always_comb begin
    penalty   = req_valid && prev_valid && !waited_q && (bank_cross || space_cross);
    req_ready = !penalty;
    accept    = req_valid && !penalty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waited_q  <= 1'b0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_space <= SP_PROG_RD;
    end else begin
      waited_q  <= penalty;
      mem_valid <= accept;
      if (accept) begin
        mem_addr  <= req_addr;
        mem_space <= req_space;
      end
    end
  end
endmodule

// File: rtl/bank_cross_waiter_chk.sv
module bank_cross_waiter_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_space,
  input logic          req_ready,
  input logic          mem_valid,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_space,
  input logic [DW-1:0] cfg_rdata
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else if (req_valid && req_ready) seen <= 1'b1;
  end

  p_reset_cfg_r1: assert property (@(posedge clk)
    rst |=> (cfg_rdata == DW'(16'h001F) && !mem_valid));

  p_first_free_r2: assert property (@(posedge clk) disable iff (rst)
    (!seen && req_valid) |-> req_ready);

  p_forward_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=>
      (mem_valid && mem_addr == $past(req_addr) && mem_space == $past(req_space)));

  p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !mem_valid);

  p_single_wait_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (!req_valid || req_ready));

  p_idle_ready_r10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> req_ready);
endmodule

bind bank_cross_waiter bank_cross_waiter_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_space(req_space), .req_ready(req_ready), .mem_valid(mem_valid),
  .mem_addr(mem_addr), .mem_space(mem_space), .cfg_rdata(cfg_rdata)
);

// File: tb/bank_cross_waiter_bench.sv
module bank_cross_waiter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_space = '0;
  logic        req_ready;
  logic        mem_valid;
  logic [15:0] mem_addr;
  logic [1:0]  mem_space;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bank_cross_waiter u_bank_cross_waiter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_space(req_space), .req_ready(req_ready), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_space(mem_space), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model state
  bit   m_init = 0;
  int   m_cfg;
  bit   m_have;
  int   m_bank;
  int   m_space;
  bit   m_waited;
  bit   m_mv;
  int   m_maddr;
  int   m_mspace;

  always @(negedge clk) begin
    bit    stall;
    string tag;
    int    mask, cb, pb;
    bit    bx, sx;
    if (m_init && !done) begin
      mask = m_cfg & 15;
      cb = (int'(req_addr) >> 12) & mask;
      pb = m_bank & mask;
      bx = (cb != pb);
      sx = (req_space[1] != m_space[1]) &&
           !(m_space == 0 && req_space == 2'b10 && !m_cfg[4]);
      stall = req_valid && m_have && !m_waited && (bx || sx);
      if (!m_have) tag = "R2";
      else if (m_waited) tag = "R11";
      else if (sx && m_space == 0 && req_space == 2'b10) tag = "R6";
      else if (sx) tag = "R5";
      else if (bx) tag = "R3";
      else tag = "R10";
      check(req_ready == !stall, {tag, " ready"}, req_ready, !stall);
      check(mem_valid == m_mv, "R7 mem_valid", mem_valid, m_mv);
      if (m_mv) begin
        check(mem_addr == m_maddr[15:0], "R7 mem_addr", mem_addr, m_maddr);
        check(mem_space == m_mspace[1:0], "R7 mem_space", mem_space, m_mspace);
      end
      check(cfg_rdata == m_cfg[15:0], "R9 cfg_rdata", cfg_rdata, m_cfg);
      if (!rst) begin
        m_mv = req_valid && !stall;
        if (m_mv) begin
          m_maddr = req_addr; m_mspace = req_space;
          m_have = 1; m_bank = int'(req_addr) >> 12; m_space = req_space;
        end
        m_waited = stall;
        if (cfg_we) m_cfg = cfg_wdata & 16'h01FF;
      end
    end
    if (rst) begin
      m_init = 1; m_cfg = 16'h001F; m_have = 0; m_waited = 0; m_mv = 0;
      m_bank = 0; m_space = 0; m_maddr = 0; m_mspace = 0;
    end
  end

  // presents one access and returns the number of wait cycles it saw
  task automatic access(input logic [15:0] a, input logic [1:0] sp, output int stalls);
    stalls = 0;
    req_valid = 1'b1; req_addr = a; req_space = sp;
    forever begin
      @(negedge clk);
      if (req_ready) break;
      stalls++;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic expect_wait(input logic [15:0] a, input logic [1:0] sp,
                             input int exp, input string req);
    int s;
    access(a, sp, s);
    check(s == exp, req, s, exp);
  endtask

  task automatic write_cfg(input logic [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(cfg_rdata == 16'h001F, "R1 cfg reset", cfg_rdata, 16'h001F);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(mem_valid == 1'b0, "R1 mem_valid", mem_valid, 0);
    @(posedge clk); #1;

    expect_wait(16'h1234, 2'b10, 0, "R2 first access");
    expect_wait(16'h1FFF, 2'b10, 0, "R10 same bank");
    expect_wait(16'h2000, 2'b10, 1, "R3 bank cross");
    expect_wait(16'h2010, 2'b00, 1, "R5 data to program");
    expect_wait(16'h2020, 2'b10, 1, "R6 prog read to data read enabled");

    write_cfg(16'h000F);
    expect_wait(16'h2000, 2'b00, 1, "R5 data to program");
    expect_wait(16'h2004, 2'b10, 0, "R6 prog read to data read disabled");
    expect_wait(16'h2008, 2'b01, 1, "R5 data to program write");
    expect_wait(16'h200C, 2'b11, 1, "R5 program write to data write");

    write_cfg(16'h001E);
    expect_wait(16'h3000, 2'b11, 0, "R4 masked bit ignored");
    expect_wait(16'h4000, 2'b11, 1, "R4 unmasked bit counts");
    write_cfg(16'h0010);
    expect_wait(16'hF000, 2'b11, 0, "R4 zero mask");

    write_cfg(16'hFFFF);
    @(negedge clk);
    check(cfg_rdata == 16'h01FF, "R9 reserved read zero", cfg_rdata, 16'h01FF);
    @(posedge clk); #1;
    expect_wait(16'h5000, 2'b11, 1, "R9 storage bits inert");
    expect_wait(16'h5004, 2'b11, 0, "R9 storage bits inert same bank");

    write_cfg(16'h001F);
    expect_wait(16'h5008, 2'b10, 0, "R10 same bank same space");
    req_valid = 1'b1; req_addr = 16'h6000; req_space = 2'b10;
    @(negedge clk);
    check(req_ready == 1'b0, "R8 stalled before withdraw", req_ready, 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(posedge clk); #1;
    expect_wait(16'h500C, 2'b10, 0, "R8 withdrawn request not recorded");

    expect_wait(16'h1000, 2'b10, 1, "R11 chain 1");
    expect_wait(16'h2000, 2'b10, 1, "R11 chain 2");
    expect_wait(16'h3000, 2'b00, 1, "R11 chain 3 bank and space");
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1 && mem_valid == 1'b0, "R10 idle", req_ready, 1);
    @(posedge clk); #1;

    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    expect_wait(16'hA000, 2'b01, 0, "R2 first after second reset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule